// File: doc/BRIEF.md
# ALU Status Flag Generator

This block sits beside a small integer datapath and turns each arithmetic or logic operation into a set of status flags. It takes two operands, an operation code and a size select (byte or word). From these it forms the operation result combinationally. On the next clock edge it stores carry, parity, auxiliary carry, zero, sign and overflow in a 16-bit flags word. Three control flags share the same word: single-step trap, interrupt enable and string direction. Each has its own set and clear strobe.

The whole flags word is visible on an output, so surrounding logic can save it, for example on a stack. A load port writes a saved word back in a single cycle. Add-with-carry and subtract-with-borrow take their carry or borrow from the stored carry flag. Increment and decrement leave that flag alone, so a loop counter can run inside a multi-word carry chain.

Top module: `alu_flag_unit`

## Requirements
- R1: After reset the flags word reads 16'h0002. Flag bit positions are: carry 0, parity 2, auxiliary carry 4, zero 6, sign 7, trap 8, interrupt enable 9, direction 10, overflow 11.
- R2: For op codes 0 (add) and 1 (add with carry), carry is the unsigned carry out of the selected width (bit 8 in byte mode, bit 16 in word mode). A byte add of 8'hFF and 8'h01 gives result 0 with carry and zero set.
- R3: For op codes 2 (subtract) and 3 (subtract with borrow), carry is the borrow. It is clear exactly when the minuend is at least the subtrahend plus the borrow-in, taken unsigned.
- R4: Overflow is set when the two's-complement result of an add, subtract, increment or decrement does not fit the selected width.
- R5: Word select 0 is byte mode and 1 is word mode. In byte mode the upper operand byte is ignored and the result's upper byte is zero. Sign copies the top bit of the selected width. Zero is set exactly when the result is all zeros.
- R6: Parity is set when result bits 7..0 hold an even number of ones (zero ones counts as even), in both modes.
- R7: Auxiliary carry is the carry or borrow from bit 3 into bit 4.
- R8: Op codes 4 (increment) and 5 (decrement) update every status flag except carry, which keeps its value.
- R9: Op codes 6 (AND), 7 (OR) and 8 (XOR) clear carry, overflow and auxiliary carry, and update sign, zero and parity.
- R10: The set and clear strobes for trap, interrupt enable and direction act on the next edge. If set and clear arrive together, clear wins. The strobes work in the same cycle as a status update.
- R11: A load writes the flags word on the next edge and overrides both updates and strobes in that cycle. Undefined bits always read fixed: bit 1 is 1, and bits 3, 5 and 15..12 are 0.
- R12: When op_valid is low, or the op code is 9..15, the status flags are unchanged. For op codes 9..15 the result is 0.
- R13: Add with carry and subtract with borrow use the stored carry flag as carry-in or borrow-in.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_valid | input | 1 | Commit the status flags of this operation on the next edge |
| op_code | input | 4 | Operation select (0..8 defined) |
| word_sel | input | 1 | 1 = word width, 0 = byte width |
| opa | input | 16 | First operand / minuend |
| opb | input | 16 | Second operand / subtrahend |
| set_trap | input | 1 | Set trap flag |
| clr_trap | input | 1 | Clear trap flag |
| set_intr | input | 1 | Set interrupt-enable flag |
| clr_intr | input | 1 | Clear interrupt-enable flag |
| set_dir | input | 1 | Set direction flag |
| clr_dir | input | 1 | Clear direction flag |
| load_en | input | 1 | Restore the flags word from load_val |
| load_val | input | 16 | Flags word to restore |
| result | output | 16 | Combinational operation result |
| flags | output | 16 | Stored flags word |

## Verification
The bench builds the block with the default widths: a 16-bit word and an 8-bit byte. Both size modes are therefore reachable, and the word splits into two byte lanes for the zero test. Under these values the bench can reach several cases: a carry out of bit 8 that must not leak into a word result, parity that ignores the upper byte, and a word-mode signed overflow at 16'h7FFF/16'h8000. The stored carry flag is preset through the load port before each table entry, so carry-in, borrow-in and carry retention are all exercised.

// File: rtl/flag_gen_pkg.sv
package flag_gen_pkg;

    localparam int FLAGS_W = 16;

    localparam int FB_CARRY  = 0;
    localparam int FB_PARITY = 2;
    localparam int FB_AUX    = 4;
    localparam int FB_ZERO   = 6;
    localparam int FB_SIGN   = 7;
    localparam int FB_TRAP   = 8;
    localparam int FB_INTR   = 9;
    localparam int FB_DIR    = 10;
    localparam int FB_OVF    = 11;

    localparam logic [FLAGS_W-1:0] DEFINED_MASK =
        FLAGS_W'((1 << FB_CARRY) | (1 << FB_PARITY) | (1 << FB_AUX) |
                 (1 << FB_ZERO)  | (1 << FB_SIGN)   | (1 << FB_TRAP) |
                 (1 << FB_INTR)  | (1 << FB_DIR)    | (1 << FB_OVF));
    localparam logic [FLAGS_W-1:0] FIXED_ONES = FLAGS_W'(16'h0002);
    localparam logic [FLAGS_W-1:0] RESET_FLAGS = FIXED_ONES;

    typedef enum logic [3:0] {
        OP_ADD = 4'd0,
        OP_ADC = 4'd1,
        OP_SUB = 4'd2,
        OP_SBB = 4'd3,
        OP_INC = 4'd4,
        OP_DEC = 4'd5,
        OP_AND = 4'd6,
        OP_OR  = 4'd7,
        OP_XOR = 4'd8
    } alu_op_e;

    typedef struct packed {
        logic ovf;
        logic sign;
        logic zero;
        logic aux;
        logic parity;
        logic carry;
    } status_t;

endpackage

// File: rtl/afu_alu_core.sv
module afu_alu_core
    import flag_gen_pkg::*;
#(
    parameter int WORD_W = 16,
    parameter int BYTE_W = 8
) (
    input  alu_op_e           op,
    input  logic              word_sel,
    input  logic [WORD_W-1:0] opa,
    input  logic [WORD_W-1:0] opb,
    input  logic              carry_in,
    output logic [WORD_W-1:0] result,
    output logic              carry_out,
    output logic              aux_out,
    output logic              ovf_out,
    output logic              op_known,
    output logic              keep_carry
);
    localparam int EXT_W = WORD_W + 1;
    localparam int NIB_W = BYTE_W / 2;
    localparam logic [WORD_W-1:0] BYTE_MASK = WORD_W'((1 << BYTE_W) - 1);

    logic [WORD_W-1:0] size_mask;
    logic [WORD_W-1:0] a_m;
    logic [WORD_W-1:0] b_m;
    logic [WORD_W-1:0] b_sel;
    logic [WORD_W-1:0] logic_res;
    logic              sub_mode;
    logic              ci;
    logic              arith;
    logic [EXT_W-1:0]  wide;
    logic [NIB_W:0]    nib;
    logic              sa;
    logic              sb;
    logic              sr;

    // operand shaping and operation decode
    always_comb begin
        size_mask  = word_sel ? '1 : BYTE_MASK;
        a_m        = opa & size_mask;
        b_m        = opb & size_mask;
        b_sel      = b_m;
        sub_mode   = 1'b0;
        ci         = 1'b0;
        arith      = 1'b0;
        logic_res  = '0;
        op_known   = 1'b1;
        keep_carry = 1'b0;
        case (op)
            OP_ADD: arith = 1'b1;
            OP_ADC: begin
                arith = 1'b1;
                ci    = carry_in;
            end
            OP_SUB: begin
                arith    = 1'b1;
                sub_mode = 1'b1;
            end
            OP_SBB: begin
                arith    = 1'b1;
                sub_mode = 1'b1;
                ci       = carry_in;
            end
            OP_INC: begin
                arith      = 1'b1;
                b_sel      = WORD_W'(1);
                keep_carry = 1'b1;
            end
            OP_DEC: begin
                arith      = 1'b1;
                sub_mode   = 1'b1;
                b_sel      = WORD_W'(1);
                keep_carry = 1'b1;
            end
            OP_AND:  logic_res = a_m & b_m;
            OP_OR:   logic_res = a_m | b_m;
            OP_XOR:  logic_res = a_m ^ b_m;
            default: op_known  = 1'b0;
        endcase
    end

    // adder / subtractor with nibble carry and signed overflow
    always_comb begin
        if (sub_mode) begin
            wide = {1'b0, a_m} - {1'b0, b_sel} - EXT_W'(ci);
            nib  = {1'b0, a_m[NIB_W-1:0]} - {1'b0, b_sel[NIB_W-1:0]} - (NIB_W+1)'(ci);
        end else begin
            wide = {1'b0, a_m} + {1'b0, b_sel} + EXT_W'(ci);
            nib  = {1'b0, a_m[NIB_W-1:0]} + {1'b0, b_sel[NIB_W-1:0]} + (NIB_W+1)'(ci);
        end
        sa = word_sel ? a_m[WORD_W-1]   : a_m[BYTE_W-1];
        sb = word_sel ? b_sel[WORD_W-1] : b_sel[BYTE_W-1];
        sr = word_sel ? wide[WORD_W-1]  : wide[BYTE_W-1];
        if (arith) begin
            result    = wide[WORD_W-1:0] & size_mask;
            carry_out = word_sel ? wide[WORD_W] : wide[BYTE_W];
            aux_out   = nib[NIB_W];
            ovf_out   = sub_mode ? ((sa != sb) && (sr != sa))
                                 : ((sa == sb) && (sr != sa));
        end else begin
            result    = logic_res;
            carry_out = 1'b0;
            aux_out   = 1'b0;
            ovf_out   = 1'b0;
        end
    end

endmodule

// File: rtl/afu_flag_eval.sv
module afu_flag_eval #(
    parameter int WORD_W = 16,
    parameter int BYTE_W = 8
) (
    input  logic [WORD_W-1:0] result,
    input  logic              word_sel,
    output logic              zero,
    output logic              sign,
    output logic              parity
);
    localparam int LANES = WORD_W / BYTE_W;

    logic [LANES-1:0] lane_zero;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lane_zero[g] = ~|result[g*BYTE_W +: BYTE_W];
    end

    always_comb begin
        zero   = word_sel ? (&lane_zero) : lane_zero[0];
        sign   = word_sel ? result[WORD_W-1] : result[BYTE_W-1];
        parity = ~^result[BYTE_W-1:0];
    end

endmodule

// File: rtl/afu_flag_reg.sv
module afu_flag_reg
    import flag_gen_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               upd_en,
    input  logic               keep_carry,
    input  status_t            st,
    input  logic               set_trap,
    input  logic               clr_trap,
    input  logic               set_intr,
    input  logic               clr_intr,
    input  logic               set_dir,
    input  logic               clr_dir,
    input  logic               load_en,
    input  logic [FLAGS_W-1:0] load_val,
    output logic [FLAGS_W-1:0] flags_q
);
    logic [FLAGS_W-1:0] flags_d;

    always_comb begin
        flags_d = flags_q;
        if (upd_en) begin
            if (!keep_carry) flags_d[FB_CARRY] = st.carry;
            flags_d[FB_PARITY] = st.parity;
            flags_d[FB_AUX]    = st.aux;
            flags_d[FB_ZERO]   = st.zero;
            flags_d[FB_SIGN]   = st.sign;
            flags_d[FB_OVF]    = st.ovf;
        end
        if (set_trap) flags_d[FB_TRAP] = 1'b1;
        if (clr_trap) flags_d[FB_TRAP] = 1'b0;
        if (set_intr) flags_d[FB_INTR] = 1'b1;
        if (clr_intr) flags_d[FB_INTR] = 1'b0;
        if (set_dir)  flags_d[FB_DIR]  = 1'b1;
        if (clr_dir)  flags_d[FB_DIR]  = 1'b0;
        if (load_en)  flags_d = load_val;
        flags_d = (flags_d & DEFINED_MASK) | FIXED_ONES;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flags_q <= RESET_FLAGS;
        else        flags_q <= flags_d;
    end

    // R8: carry survives increment/decrement
    p_keep_carry_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_en && keep_carry && !load_en) |=> (flags_q[FB_CARRY] == $past(flags_q[FB_CARRY])));

    // R11: load overrides everything else in its cycle
    p_load_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
        load_en |=> ((flags_q[FB_CARRY] == $past(load_val[FB_CARRY])) &&
                     (flags_q[FB_DIR]   == $past(load_val[FB_DIR]))   &&
                     (flags_q[FB_OVF]   == $past(load_val[FB_OVF]))   &&
                     flags_q[1] && !flags_q[3]));

    // R10: clear beats set
    p_dir_clear_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (set_dir && clr_dir && !load_en) |=> !flags_q[FB_DIR]);

    // R12: nothing requested, nothing changes
    p_idle_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (!upd_en && !load_en && !set_trap && !clr_trap && !set_intr &&
         !clr_intr && !set_dir && !clr_dir) |=> $stable(flags_q));

endmodule

// File: rtl/alu_flag_unit.sv
module alu_flag_unit
    import flag_gen_pkg::*;
#(
    parameter int WORD_W = 16,
    parameter int BYTE_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               op_valid,
    input  logic [3:0]         op_code,
    input  logic               word_sel,
    input  logic [WORD_W-1:0]  opa,
    input  logic [WORD_W-1:0]  opb,
    input  logic               set_trap,
    input  logic               clr_trap,
    input  logic               set_intr,
    input  logic               clr_intr,
    input  logic               set_dir,
    input  logic               clr_dir,
    input  logic               load_en,
    input  logic [FLAGS_W-1:0] load_val,
    output logic [WORD_W-1:0]  result,
    output logic [FLAGS_W-1:0] flags
);
    alu_op_e op_e;
    logic    carry_out;
    logic    aux_out;
    logic    ovf_out;
    logic    op_known;
    logic    keep_carry;
    logic    zero_f;
    logic    sign_f;
    logic    parity_f;
    logic    upd_en;
    logic    is_logic;
    status_t st;

    assign op_e = alu_op_e'(op_code);

    afu_alu_core #(.WORD_W(WORD_W), .BYTE_W(BYTE_W)) u_core (
        .op         (op_e),
        .word_sel   (word_sel),
        .opa        (opa),
        .opb        (opb),
        .carry_in   (flags[FB_CARRY]),
        .result     (result),
        .carry_out  (carry_out),
        .aux_out    (aux_out),
        .ovf_out    (ovf_out),
        .op_known   (op_known),
        .keep_carry (keep_carry)
    );

    afu_flag_eval #(.WORD_W(WORD_W), .BYTE_W(BYTE_W)) u_eval (
        .result   (result),
        .word_sel (word_sel),
        .zero     (zero_f),
        .sign     (sign_f),
        .parity   (parity_f)
    );

    always_comb begin
        upd_en    = op_valid && op_known;
        is_logic  = (op_e == OP_AND) || (op_e == OP_OR) || (op_e == OP_XOR);
        st.ovf    = ovf_out;
        st.sign   = sign_f;
        st.zero   = zero_f;
        st.aux    = aux_out;
        st.parity = parity_f;
        st.carry  = carry_out;
    end

    afu_flag_reg u_reg (
        .clk        (clk),
        .rst_n      (rst_n),
        .upd_en     (upd_en),
        .keep_carry (keep_carry),
        .st         (st),
        .set_trap   (set_trap),
        .clr_trap   (clr_trap),
        .set_intr   (set_intr),
        .clr_intr   (clr_intr),
        .set_dir    (set_dir),
        .clr_dir    (clr_dir),
        .load_en    (load_en),
        .load_val   (load_val),
        .flags_q    (flags)
    );

    // R5: stored zero flag matches the committed result
    p_zero_match_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_known && !load_en) |=> (flags[FB_ZERO] == ($past(result) == '0)));

    // R6: parity reflects low byte of the committed result
    p_parity_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_known && !load_en) |=> (flags[FB_PARITY] == ~^($past(result[BYTE_W-1:0]))));

    // R9: logic ops leave carry, overflow and aux cleared
    p_logic_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && is_logic && !load_en) |=>
            (!flags[FB_CARRY] && !flags[FB_OVF] && !flags[FB_AUX]));

endmodule

// File: tb/alu_flag_unit_bench.sv
`timescale 1ns/1ps
module alu_flag_unit_bench;
    localparam int NV = 19;

    // fields: op[59:56] word[55] cin[54] a[53:38] b[37:22] res[21:6] st[5:0]={OF,SF,ZF,AF,PF,CF}
    localparam logic [59:0] VEC [0:NV-1] = '{
        {4'd0, 1'b0, 1'b0, 16'h00FF, 16'h0001, 16'h0000, 6'b001111},
        {4'd0, 1'b0, 1'b0, 16'h007F, 16'h0001, 16'h0080, 6'b110100},
        {4'd0, 1'b1, 1'b0, 16'h1234, 16'h4321, 16'h5555, 6'b000010},
        {4'd1, 1'b1, 1'b1, 16'hFFFF, 16'h0000, 16'h0000, 6'b001111},
        {4'd2, 1'b0, 1'b0, 16'h0005, 16'h0007, 16'h00FE, 6'b010101},
        {4'd2, 1'b1, 1'b0, 16'h8000, 16'h0001, 16'h7FFF, 6'b100110},
        {4'd3, 1'b0, 1'b1, 16'h0010, 16'h000F, 16'h0000, 6'b001110},
        {4'd2, 1'b0, 1'b0, 16'h0033, 16'h0033, 16'h0000, 6'b001010},
        {4'd4, 1'b0, 1'b1, 16'h00FF, 16'h0000, 16'h0000, 6'b001111},
        {4'd4, 1'b1, 1'b0, 16'h7FFF, 16'h0000, 16'h8000, 6'b110110},
        {4'd5, 1'b0, 1'b0, 16'h0000, 16'h0000, 16'h00FF, 6'b010110},
        {4'd5, 1'b1, 1'b1, 16'h0001, 16'h0000, 16'h0000, 6'b001011},
        {4'd6, 1'b1, 1'b1, 16'hF0F0, 16'h0FFF, 16'h00F0, 6'b000010},
        {4'd7, 1'b0, 1'b0, 16'h0080, 16'h0001, 16'h0081, 6'b010010},
        {4'd8, 1'b1, 1'b1, 16'hAAAA, 16'hAAAA, 16'h0000, 6'b001010},
        {4'd0, 1'b0, 1'b0, 16'h12FF, 16'h3401, 16'h0000, 6'b001111},
        {4'd0, 1'b1, 1'b0, 16'h0100, 16'h0000, 16'h0100, 6'b000010},
        {4'd3, 1'b1, 1'b1, 16'h0000, 16'h0000, 16'hFFFF, 6'b010111},
        {4'd2, 1'b0, 1'b0, 16'h0080, 16'h0001, 16'h007F, 6'b100100}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic [3:0]  op_code = '0;
    logic        word_sel = 1'b0;
    logic [15:0] opa = '0;
    logic [15:0] opb = '0;
    logic        set_trap = 1'b0, clr_trap = 1'b0;
    logic        set_intr = 1'b0, clr_intr = 1'b0;
    logic        set_dir = 1'b0, clr_dir = 1'b0;
    logic        load_en = 1'b0;
    logic [15:0] load_val = '0;
    logic [15:0] result;
    logic [15:0] flags;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #2.5 clk = ~clk;

    alu_flag_unit u_alu_flag_unit (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
        .word_sel(word_sel), .opa(opa), .opb(opb),
        .set_trap(set_trap), .clr_trap(clr_trap), .set_intr(set_intr),
        .clr_intr(clr_intr), .set_dir(set_dir), .clr_dir(clr_dir),
        .load_en(load_en), .load_val(load_val),
        .result(result), .flags(flags)
    );

    task automatic check16(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic string tag_of(input logic [3:0] op);
        case (op)
            4'd0:        return "R2 R4 R5 R6 R7";
            4'd1:        return "R13 R2 R4";
            4'd2:        return "R3 R4 R7";
            4'd3:        return "R13 R3";
            4'd4, 4'd5:  return "R8";
            default:     return "R9";
        endcase
    endfunction

    task automatic load_word(input logic [15:0] v);
        @(negedge clk);
        load_en  = 1'b1;
        load_val = v;
        @(negedge clk);
        load_en  = 1'b0;
    endtask

    task automatic pulse_ctl(input logic st_, ct_, si_, ci_, sd_, cd_);
        @(negedge clk);
        set_trap = st_; clr_trap = ct_; set_intr = si_;
        clr_intr = ci_; set_dir = sd_;  clr_dir = cd_;
        @(negedge clk);
        set_trap = 0; clr_trap = 0; set_intr = 0;
        clr_intr = 0; set_dir = 0;  clr_dir = 0;
    endtask

    initial begin
        #(5.0 * 20000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check16("R1 reset value during reset", flags, 16'h0002);
        rst_n = 1'b1;
        @(negedge clk);
        check16("R1 reset value after release", flags, 16'h0002);

        // table walk
        for (int i = 0; i < NV; i++) begin
            logic [59:0] v;
            logic [15:0] exp_f;
            v = VEC[i];
            load_word({15'b0, v[54]});
            @(negedge clk);
            op_valid = 1'b1;
            op_code  = v[59:56];
            word_sel = v[55];
            opa      = v[53:38];
            opb      = v[37:22];
            #1;
            check16({tag_of(v[59:56]), " result"}, result, v[21:6]);
            exp_f = 16'h0002 | {4'b0, v[5], 3'b0, v[4], v[3], 1'b0, v[2], 1'b0, v[1], 1'b0, v[0]};
            @(negedge clk);
            op_valid = 1'b0;
            check16({tag_of(v[59:56]), " flags"}, flags, exp_f);
        end

        // control strobes
        load_word(16'h0000);
        check16("R11 load zero keeps bit1", flags, 16'h0002);
        pulse_ctl(0, 0, 0, 0, 1, 0);
        check16("R10 set direction", flags, 16'h0402);
        pulse_ctl(1, 0, 1, 0, 0, 0);
        check16("R10 set trap and intr", flags, 16'h0702);
        pulse_ctl(0, 0, 0, 0, 1, 1);
        check16("R10 clear wins over set", flags, 16'h0302);

        // strobe alongside a status update: byte add 01+01 = 02, odd parity
        @(negedge clk);
        op_valid = 1'b1; op_code = 4'd0; word_sel = 1'b0;
        opa = 16'h0001; opb = 16'h0001; clr_intr = 1'b1;
        @(negedge clk);
        op_valid = 1'b0; clr_intr = 1'b0;
        check16("R10 strobe with update", flags, 16'h0102);

        // load overrides update and strobes
        @(negedge clk);
        load_en = 1'b1; load_val = 16'hFFFF;
        op_valid = 1'b1; op_code = 4'd0; opa = 16'h00FF; opb = 16'h0001;
        clr_trap = 1'b1; clr_dir = 1'b1;
        @(negedge clk);
        load_en = 1'b0; op_valid = 1'b0; clr_trap = 1'b0; clr_dir = 1'b0;
        check16("R11 load priority and fixed bits", flags, 16'h0FD7);

        // reserved op code: no flag change, zero result
        @(negedge clk);
        op_valid = 1'b1; op_code = 4'd12; word_sel = 1'b1;
        opa = 16'h1234; opb = 16'h0001;
        #1;
        check16("R12 reserved op result", result, 16'h0000);
        @(negedge clk);
        op_valid = 1'b0;
        check16("R12 reserved op keeps flags", flags, 16'h0FD7);

        // op_valid low: no flag change
        @(negedge clk);
        op_code = 4'd0; word_sel = 1'b0; opa = 16'h0001; opb = 16'h0001;
        @(negedge clk);
        check16("R12 idle keeps flags", flags, 16'h0FD7);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

endmodule